// File: doc/BRIEF.md
# Row-Column Decoded Static RAM

This block is a 1024-word by 4-bit static memory. Its bits sit in a square grid of 64 rows by 64 columns. A word address is split in two. The low field picks one row line through a row decoder. The high field picks one group of four adjacent columns through a column decoder. Only the four cells where the active row crosses the selected group take part in an access.

Data moves over a single 4-bit bidirectional bus. Two active-low controls set the direction: a chip select and a write enable. A higher-level address decoder drives the chip select, so several of these blocks can share one address bus and one data bus. Writes are captured on the rising clock edge. Read data follows the address combinationally while the block is selected for reading.

Top module: `sram_grid_top`

## Requirements
- R1: After reset every one of the 1024 words reads back as 4'h0.
- R2: When `cs_n`=0 and `we_n`=0 at a rising edge of `clk`, the value on `data` is stored in the word at `addr`. A later read of that address returns it.
- R3: With `cs_n`=0 and `we_n`=1, the block drives `data` with the word at the current `addr`. A change of `addr` shows on `data` without waiting for a clock edge.
- R4: A read never changes stored contents. Repeated reads of a word, and reads of other words in between, return the same value.
- R5: With `cs_n`=1, the block leaves `data` at high impedance (4'bzzzz), whatever the state of `we_n`.
- R6: With `cs_n`=1, a rising edge with `we_n`=0 leaves every stored word unchanged.
- R7: While `we_n`=0 with `cs_n`=0, the block does not drive `data`. The bus acts as an input.
- R8: Address bits [5:0] pick the row and bits [9:6] pick the column group. Bit i of a word lives in column 4*group+i of its row. A write touches exactly one row and exactly four columns, so all 1024 words hold independent values.
- R9: The extreme addresses 0, 63, 64 and 1023 (row and group boundaries) store and return values without disturbing their neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Active-low reset; clears every cell |
| addr | input | 10 | Word address: [5:0] row, [9:6] column group |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable; high means read |
| data | inout | 4 | Bidirectional data bus |

## Verification
A wrong cell, or a decoder line that fires at the wrong place, shows up at the port on the first read of the affected address. Because read data is combinational, it appears in the same cycle as the address. A write that spills into the wrong row or group is invisible until some other word is read back. For that reason the bench fills every word with a distinct, address-derived pattern and then sweeps the whole space. Bus contention or a missing release shows within a single half clock period, as X or as a driven value where high impedance is expected.

// File: rtl/sram_grid_pkg.sv
package sram_grid_pkg;

   localparam int unsigned DEF_ROW_BITS = 6;
   localparam int unsigned DEF_GRP_BITS = 4;
   localparam int unsigned DEF_WORD_W   = 4;

   // Row decoder variants selected at elaboration
   typedef enum logic [0:0] {
      ROWDEC_FLAT     = 1'b0,   // one full-width compare per row
      ROWDEC_PREDECODE = 1'b1   // two partial one-hot fields ANDed
   } rowdec_style_e;

   function automatic int unsigned pow2(input int unsigned bits);
      return 32'd1 << bits;
   endfunction

endpackage

// File: rtl/sram_row_decoder.sv
module sram_row_decoder
   import sram_grid_pkg::*;
#(
   parameter int unsigned   ROW_BITS = DEF_ROW_BITS,
   parameter rowdec_style_e STYLE    = ROWDEC_PREDECODE
) (
   input  logic [ROW_BITS-1:0]       row_addr,
   output logic [pow2(ROW_BITS)-1:0] row_sel
);

   localparam int unsigned ROWS    = pow2(ROW_BITS);
   localparam int unsigned LO_BITS = ROW_BITS / 2;
   localparam int unsigned HI_BITS = ROW_BITS - LO_BITS;
   localparam int unsigned LO_N    = pow2(LO_BITS);
   localparam int unsigned HI_N    = pow2(HI_BITS);

   if (ROW_BITS < 2) begin : g_chk_rows
      $error("sram_row_decoder: ROW_BITS must be at least 2");
   end

   if (STYLE == ROWDEC_FLAT) begin : g_flat
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign row_sel[r] = (row_addr == r[ROW_BITS-1:0]);
      end
   end else begin : g_pre
      logic [LO_N-1:0] lo_hot;
      logic [HI_N-1:0] hi_hot;
      for (genvar l = 0; l < LO_N; l++) begin : g_lo
         assign lo_hot[l] = (row_addr[LO_BITS-1:0] == l[LO_BITS-1:0]);
      end
      for (genvar h = 0; h < HI_N; h++) begin : g_hi
         assign hi_hot[h] = (row_addr[ROW_BITS-1:LO_BITS] == h[HI_BITS-1:0]);
      end
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign row_sel[r] = hi_hot[r / LO_N] & lo_hot[r % LO_N];
      end
   end

endmodule

// File: rtl/sram_col_decoder.sv
module sram_col_decoder
   import sram_grid_pkg::*;
#(
   parameter int unsigned GRP_BITS = DEF_GRP_BITS,
   parameter int unsigned WORD_W   = DEF_WORD_W
) (
   input  logic [GRP_BITS-1:0]              grp_addr,
   output logic [pow2(GRP_BITS)-1:0]        grp_sel,
   output logic [pow2(GRP_BITS)*WORD_W-1:0] col_en
);

   localparam int unsigned GROUPS = pow2(GRP_BITS);

   if (WORD_W < 1) begin : g_chk_w
      $error("sram_col_decoder: WORD_W must be at least 1");
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_sel[g] = (grp_addr == g[GRP_BITS-1:0]);
      // each group enables WORD_W adjacent columns
      for (genvar i = 0; i < WORD_W; i++) begin : g_bit
         assign col_en[g*WORD_W + i] = grp_sel[g];
      end
   end

endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array
   import sram_grid_pkg::*;
#(
   parameter int unsigned ROWS   = pow2(DEF_ROW_BITS),
   parameter int unsigned GROUPS = pow2(DEF_GRP_BITS),
   parameter int unsigned WORD_W = DEF_WORD_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ROWS-1:0]            row_sel,
   input  logic [GROUPS*WORD_W-1:0]   col_en,
   input  logic                       wr_en,
   input  logic [WORD_W-1:0]          wdata,
   output logic [GROUPS*WORD_W-1:0]   bitline
);

   localparam int unsigned COLS = GROUPS * WORD_W;

   if (ROWS * COLS > 65536) begin : g_chk_size
      $error("sram_cell_array: array larger than supported");
   end

   // write data fanned out across every column group
   logic [COLS-1:0]            wide_data;
   logic [ROWS-1:0][COLS-1:0]  tap;

   assign wide_data = {GROUPS{wdata}};

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] cells_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells_q <= '0;
         end else if (wr_en && row_sel[r]) begin
            cells_q <= (cells_q & ~col_en) | (wide_data & col_en);
         end
      end
      // a cell reaches its column line only when its row line is high
      assign tap[r] = cells_q & {COLS{row_sel[r]}};
   end

   always_comb begin
      bitline = '0;
      for (int r = 0; r < ROWS; r++) begin
         bitline = bitline | tap[r];
      end
   end

endmodule

// File: rtl/sram_col_mux.sv
module sram_col_mux
   import sram_grid_pkg::*;
#(
   parameter int unsigned GROUPS = pow2(DEF_GRP_BITS),
   parameter int unsigned WORD_W = DEF_WORD_W
) (
   input  logic [GROUPS-1:0]        grp_sel,
   input  logic [GROUPS*WORD_W-1:0] bitline,
   output logic [WORD_W-1:0]        rdata
);

   always_comb begin
      rdata = '0;
      for (int g = 0; g < GROUPS; g++) begin
         rdata = rdata | (bitline[g*WORD_W +: WORD_W] & {WORD_W{grp_sel[g]}});
      end
   end

endmodule

// File: rtl/sram_grid_top.sv
module sram_grid_top
   import sram_grid_pkg::*;
#(
   parameter int unsigned   ROW_BITS  = DEF_ROW_BITS,
   parameter int unsigned   GRP_BITS  = DEF_GRP_BITS,
   parameter int unsigned   WORD_W    = DEF_WORD_W,
   parameter rowdec_style_e ROW_STYLE = ROWDEC_PREDECODE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ROW_BITS+GRP_BITS-1:0] addr,
   input  logic                         cs_n,
   input  logic                         we_n,
   inout  wire  [WORD_W-1:0]            data
);

   localparam int unsigned ADDR_W = ROW_BITS + GRP_BITS;
   localparam int unsigned ROWS   = pow2(ROW_BITS);
   localparam int unsigned GROUPS = pow2(GRP_BITS);
   localparam int unsigned COLS   = GROUPS * WORD_W;

   if (ADDR_W > 16) begin : g_chk_addr
      $error("sram_grid_top: address wider than supported");
   end

   logic [ROWS-1:0]   row_sel;
   logic [GROUPS-1:0] grp_sel;
   logic [COLS-1:0]   col_en;
   logic [COLS-1:0]   bitline;
   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] wr_word;
   logic              wr_en;
   logic              rd_oe;

   assign wr_en   = !cs_n && !we_n;
   assign rd_oe   = !cs_n &&  we_n;
   assign wr_word = data;
   assign data    = rd_oe ? rd_word : {WORD_W{1'bz}};

   sram_row_decoder #(
      .ROW_BITS (ROW_BITS),
      .STYLE    (ROW_STYLE)
   ) u_rowdec (
      .row_addr (addr[ROW_BITS-1:0]),
      .row_sel  (row_sel)
   );

   sram_col_decoder #(
      .GRP_BITS (GRP_BITS),
      .WORD_W   (WORD_W)
   ) u_coldec (
      .grp_addr (addr[ADDR_W-1:ROW_BITS]),
      .grp_sel  (grp_sel),
      .col_en   (col_en)
   );

   sram_cell_array #(
      .ROWS   (ROWS),
      .GROUPS (GROUPS),
      .WORD_W (WORD_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_sel (row_sel),
      .col_en  (col_en),
      .wr_en   (wr_en),
      .wdata   (wr_word),
      .bitline (bitline)
   );

   sram_col_mux #(
      .GROUPS (GROUPS),
      .WORD_W (WORD_W)
   ) u_mux (
      .grp_sel (grp_sel),
      .bitline (bitline),
      .rdata   (rd_word)
   );

   AST_ONE_ROW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_sel) == 1);                                        // R8

   AST_ONE_COL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_en) == WORD_W);                                    // R8

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (addr != $past(addr)) || (rd_word == $past(wr_word)));  // R2

   AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (addr != $past(addr)) || (rd_word == $past(rd_word))); // R4

endmodule

// File: tb/tb_sram_grid_top.sv
`timescale 1ns/1ps
module tb_sram_grid_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] addr = '0;
   logic       cs_n = 1'b1;
   logic       we_n = 1'b1;
   logic [3:0] tb_drv = '0;
   logic       tb_oe = 1'b0;
   wire  [3:0] data;

   int n_checks = 0;
   int n_fails  = 0;

   assign data = tb_oe ? tb_drv : 4'bzzzz;

   always #2.5 clk = ~clk;

   sram_grid_top dut (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .cs_n  (cs_n),
      .we_n  (we_n),
      .data  (data)
   );

   function automatic logic [3:0] pat(input logic [9:0] a, input logic [3:0] k);
      return a[3:0] ^ {a[7:6], a[5:4]} ^ {2'b00, a[9:8]} ^ k ^ {a[9], a[0], a[6], a[3]};
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [9:0] a, input logic [3:0] d);
      @(negedge clk);
      addr = a; tb_drv = d; tb_oe = 1'b1; cs_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; tb_oe = 1'b0;
   endtask

   task automatic do_read(input logic [9:0] a, output logic [3:0] d);
      @(negedge clk);
      addr = a; tb_oe = 1'b0; cs_n = 1'b0; we_n = 1'b1;
      #1 d = data;
   endtask

   // R1: every word clear after reset
   task automatic t_reset_state();
      logic [3:0] v;
      for (int a = 0; a < 1024; a++) begin
         do_read(a[9:0], v);
         check("R1", v, 4'h0);
      end
      cs_n = 1'b1;
   endtask

   // R2, R8: fill every word, sweep back; R4: second sweep unchanged
   task automatic t_fill_sweep(input logic [3:0] k);
      logic [3:0] v;
      for (int a = 0; a < 1024; a++) do_write(a[9:0], pat(a[9:0], k));
      for (int a = 0; a < 1024; a++) begin
         do_read(a[9:0], v);
         check("R2/R8", v, pat(a[9:0], k));
      end
      for (int a = 1023; a >= 0; a--) begin
         do_read(a[9:0], v);
         check("R4", v, pat(a[9:0], k));
      end
      cs_n = 1'b1;
   endtask

   // R3: address change inside one low phase, no clock edge
   task automatic t_comb_read(input logic [3:0] k);
      @(negedge clk);
      cs_n = 1'b0; we_n = 1'b1; tb_oe = 1'b0; addr = 10'd5;
      #0.5 check("R3", data, pat(10'd5, k));
      addr = 10'd700;
      #0.5 check("R3", data, pat(10'd700, k));
      addr = 10'd129;
      #0.5 check("R3", data, pat(10'd129, k));
      cs_n = 1'b1;
   endtask

   // R5: released bus when deselected, with either we_n level
   task automatic t_release();
      @(negedge clk);
      tb_oe = 1'b0; cs_n = 1'b1; we_n = 1'b1; addr = 10'd300;
      #1 check("R5", data, 4'bzzzz);
      we_n = 1'b0;
      #0.5 check("R5", data, 4'bzzzz);
      we_n = 1'b1;
   endtask

   // R6: deselected write strobe ignored
   task automatic t_ignore_write(input logic [3:0] k);
      logic [3:0] v;
      for (int j = 0; j < 4; j++) begin
         logic [9:0] a = 10'(j * 257);
         @(negedge clk);
         addr = a; tb_drv = ~pat(a, k); tb_oe = 1'b1; cs_n = 1'b1; we_n = 1'b0;
         @(negedge clk);
         we_n = 1'b1; tb_oe = 1'b0;
         do_read(a, v);
         check("R6", v, pat(a, k));
      end
      cs_n = 1'b1;
   endtask

   // R7: block not driving during a write phase
   task automatic t_write_input();
      @(negedge clk);
      tb_oe = 1'b0; addr = 10'd42; cs_n = 1'b0; we_n = 1'b0;
      #0.5 check("R7", data, 4'bzzzz);
      cs_n = 1'b1; we_n = 1'b1;
   endtask

   // R9: boundary words and their neighbours
   task automatic t_bounds(input logic [3:0] k);
      logic [3:0] v;
      logic [9:0] edges [4] = '{10'd0, 10'd63, 10'd64, 10'd1023};
      for (int j = 0; j < 4; j++) do_write(edges[j], ~pat(edges[j], k));
      for (int j = 0; j < 4; j++) begin
         do_read(edges[j], v);
         check("R9", v, ~pat(edges[j], k));
      end
      do_read(10'd1, v);    check("R9", v, pat(10'd1, k));
      do_read(10'd62, v);   check("R9", v, pat(10'd62, k));
      do_read(10'd65, v);   check("R9", v, pat(10'd65, k));
      do_read(10'd1022, v); check("R9", v, pat(10'd1022, k));
      do_read(10'd127, v);  check("R9", v, pat(10'd127, k));
      do_read(10'd959, v);  check("R9", v, pat(10'd959, k));
      cs_n = 1'b1;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_fill_sweep(4'h0);
      t_comb_read(4'h0);
      t_release();
      t_ignore_write(4'h0);
      t_write_input();
      t_bounds(4'h0);
      t_fill_sweep(4'hA);
      t_comb_read(4'hA);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule